// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps, for every tracked line, a short list of the cores that hold a copy. Each list entry is a core index of log2(core count) bits with its own valid flag. It does not keep one presence bit per core. The list has a fixed number of slots, three by default, so it caps how many cores can share a line at once. Requests arrive one at a time over a valid/ready port. Each request names a line, a core and one of three operations:
- a shared read, which adds the core as a sharer;
- an exclusive write, which makes the core the only holder;
- an eviction, which removes the core.

When a request needs other cores to drop their copies, the block sends point-to-point invalidate messages. Each message names one target core and the line, and each waits on its own valid/ready handshake. No message is broadcast. When a read finds every slot in use, the oldest recorded sharer is invalidated before the new core takes a slot.

The slots of an entry are kept packed and in arrival order: slot 0 holds the oldest sharer. Once every message of a request has been accepted, a one-cycle completion pulse closes the request and the entry update takes effect.

Top module: `sharer_dir`

## Requirements
- R1: After reset every line has no sharers, `req_ready` is 1, and `inv_valid` and `done` are 0.
- R2: A shared read (op code 0) from a core that is not listed, on a line with a free slot, records that core, sends no invalidate, and pulses `done` in the cycle after acceptance.
- R3: A shared read from a core that is already listed changes nothing and sends no invalidate.
- R4: A shared read from an unlisted core when all slots are in use first sends one invalidate to the oldest recorded sharer. The oldest sharer is the earliest added that is still present. That core is then dropped, and the new core is recorded as the newest sharer.
- R5: An exclusive write (op code 1) sends an invalidate to every listed core except the requester, one per accepted handshake, oldest first. Afterwards the line lists only the requester.
- R6: An eviction (op code 2) removes the named core from the line and keeps the order of the remaining sharers. An eviction for a core that is not listed changes nothing.
- R7: While `inv_valid` is 1 and `inv_ready` is 0, `inv_valid`, `inv_core` and `inv_line` hold steady. `inv_line` equals the request's line. `done` is high for exactly one cycle: the cycle after the last invalidate is accepted, or the cycle after acceptance if there are none.
- R8: `req_ready` is 0 from the cycle after a request is accepted up to and including its `done` cycle.
- R9: Requests on one line never change the sharer list of another line.
- R10: Op code 3 is ignored: it changes no entry, sends no invalidate, and still completes with a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 shared read, 1 exclusive write, 2 evict, 3 ignored |
| req_line | input | LINE_W (4) | Directory line index |
| req_core | input | CORE_W (3) | Requesting core |
| inv_valid | output | 1 | Invalidate message present |
| inv_ready | input | 1 | Invalidate message taken by the network |
| inv_core | output | CORE_W (3) | Target core of the invalidate |
| inv_line | output | LINE_W (4) | Line to invalidate |
| done | output | 1 | One-cycle completion pulse |

## Verification
A request that needs no messages completes one cycle after its accepting edge. With `inv_ready` held high, the k-th invalidate is visible k cycles after acceptance, and `done` follows the last one by one cycle. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. It counts the sampled cycles up to `done`, so the cycle count is checked directly against the number of expected messages. Sharer lists are read back at the ports: an exclusive write from a core that is not listed produces invalidates that show the stored cores in age order. One directed case holds `inv_ready` low for several cycles and checks that the pending message stays stable and that `done` does not appear early.

// File: rtl/sharer_dir_pkg.sv
package sharer_dir_pkg;

  typedef enum logic [1:0] {
    DIR_RD  = 2'd0,
    DIR_WR  = 2'd1,
    DIR_EV  = 2'd2,
    DIR_NOP = 2'd3
  } dir_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2
  } dir_state_e;

endpackage

// File: rtl/sharer_dir_table.sv
module sharer_dir_table #(
  parameter int NUM_LINES = 16,
  parameter int NUM_SLOTS = 3,
  parameter int CORE_W    = 3,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PTR_W    = NUM_SLOTS * CORE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output logic [NUM_SLOTS-1:0] rd_vld,
  output logic [PTR_W-1:0]  rd_ptr,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [NUM_SLOTS-1:0] wr_vld,
  input  logic [PTR_W-1:0]  wr_ptr
);

  logic [NUM_SLOTS-1:0] vld_q [NUM_LINES];
  logic [PTR_W-1:0]     ptr_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic line_we;
    assign line_we = wr_en && (wr_line == LINE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= '0;
        ptr_q[g] <= '0;
      end else if (line_we) begin
        vld_q[g] <= wr_vld;
        ptr_q[g] <= wr_ptr;
      end
    end
  end

  assign rd_vld = vld_q[rd_line];
  assign rd_ptr = ptr_q[rd_line];

  // An entry is well formed when its valid slots are packed from slot 0
  // and no core appears twice.
  function automatic logic entry_ok(input logic [NUM_SLOTS-1:0] v,
                                    input logic [PTR_W-1:0] p);
    logic ok;
    ok = ((v & (v + 1'b1)) == '0);
    for (int i = 0; i < NUM_SLOTS; i++)
      for (int j = i + 1; j < NUM_SLOTS; j++)
        if (v[i] && v[j] && (p[i*CORE_W +: CORE_W] == p[j*CORE_W +: CORE_W]))
          ok = 1'b0;
    return ok;
  endfunction

  // R4, R6: the FIFO age order relies on packed slots with no duplicates
  assert_packed_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> entry_ok(wr_vld, wr_ptr));

endmodule

// File: rtl/sharer_dir_pick.sv
module sharer_dir_pick #(
  parameter int W      = 3,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     mask,
  output logic [W-1:0]     first,
  output logic [IDX_W-1:0] idx
);

  for (genvar g = 0; g < W; g++) begin : g_first
    if (g == 0) begin : g_lo
      assign first[g] = mask[g];
    end else begin : g_hi
      assign first[g] = mask[g] && !(|mask[g-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (first[i]) idx = idx | IDX_W'(i);
  end

endmodule

// File: rtl/sharer_dir_update.sv
module sharer_dir_update
  import sharer_dir_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int CORE_W    = 3,
  localparam int PTR_W    = NUM_SLOTS * CORE_W
) (
  input  dir_op_e              op_i,
  input  logic [CORE_W-1:0]    core_i,
  input  logic [NUM_SLOTS-1:0] vld_i,
  input  logic [PTR_W-1:0]     ptr_i,
  output logic [NUM_SLOTS-1:0] inv_mask_o,
  output logic [NUM_SLOTS-1:0] vld_o,
  output logic [PTR_W-1:0]     ptr_o
);

  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] free_first;
  logic [NUM_SLOTS-1:0] rm_sel;
  logic [NUM_SLOTS-1:0] at_or_above;
  logic [NUM_SLOTS-1:0] sh_vld;
  logic [PTR_W-1:0]     sh_ptr;
  logic                 full;
  logic                 listed;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      hit[i] = vld_i[i] && (ptr_i[i*CORE_W +: CORE_W] == core_i);
  end

  assign listed     = |hit;
  assign full       = &vld_i;
  assign free_first = ~vld_i & (vld_i + 1'b1);

  // slot removed this request: oldest on overflow, matching slot on evict
  always_comb begin
    rm_sel = '0;
    if (op_i == DIR_RD && full && !listed) rm_sel[0] = 1'b1;
    else if (op_i == DIR_EV)               rm_sel = hit;
  end

  // shift every slot at or above the removed one down by one place
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      acc = acc | rm_sel[i];
      at_or_above[i] = acc;
    end
    sh_vld = vld_i;
    sh_ptr = ptr_i;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (at_or_above[i]) begin
        if (i < NUM_SLOTS - 1) begin
          sh_vld[i] = vld_i[i+1];
          sh_ptr[i*CORE_W +: CORE_W] = ptr_i[(i+1)*CORE_W +: CORE_W];
        end else begin
          sh_vld[i] = 1'b0;
          sh_ptr[i*CORE_W +: CORE_W] = '0;
        end
      end
    end
  end

  always_comb begin
    inv_mask_o = '0;
    vld_o      = vld_i;
    ptr_o      = ptr_i;
    unique case (op_i)
      DIR_RD: begin
        if (!listed && !full) begin
          for (int i = 0; i < NUM_SLOTS; i++)
            if (free_first[i]) begin
              vld_o[i] = 1'b1;
              ptr_o[i*CORE_W +: CORE_W] = core_i;
            end
        end else if (!listed) begin
          inv_mask_o[0] = 1'b1;
          vld_o = sh_vld;
          ptr_o = sh_ptr;
          vld_o[NUM_SLOTS-1] = 1'b1;
          ptr_o[(NUM_SLOTS-1)*CORE_W +: CORE_W] = core_i;
        end
      end
      DIR_WR: begin
        inv_mask_o = vld_i & ~hit;
        vld_o      = '0;
        ptr_o      = '0;
        vld_o[0]   = 1'b1;
        ptr_o[0 +: CORE_W] = core_i;
      end
      DIR_EV: begin
        vld_o = sh_vld;
        ptr_o = sh_ptr;
      end
      default: begin
        vld_o = vld_i;
        ptr_o = ptr_i;
      end
    endcase
  end

endmodule

// File: rtl/sharer_dir.sv
module sharer_dir
  import sharer_dir_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_CORES = 8,
  parameter int NUM_SLOTS = 3,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PTR_W    = NUM_SLOTS * CORE_W,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [LINE_W-1:0] req_line,
  input  logic [CORE_W-1:0] req_core,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [CORE_W-1:0] inv_core,
  output logic [LINE_W-1:0] inv_line,
  output logic              done
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dir_state_e           state_q, state_d;
  dir_op_e              op_q;
  logic [LINE_W-1:0]    line_q;
  logic [CORE_W-1:0]    core_q;
  logic [PTR_W-1:0]     cur_ptr_q;
  logic [NUM_SLOTS-1:0] mask_q, mask_d;
  logic [NUM_SLOTS-1:0] nxt_vld_q;
  logic [PTR_W-1:0]     nxt_ptr_q;

  logic [NUM_SLOTS-1:0] rd_vld;
  logic [PTR_W-1:0]     rd_ptr;
  logic [NUM_SLOTS-1:0] upd_mask, upd_vld;
  logic [PTR_W-1:0]     upd_ptr;
  logic [NUM_SLOTS-1:0] pick_first;
  logic [IDX_W-1:0]     pick_idx;
  logic                 accept, fire, load_en, mask_en;

  sharer_dir_table #(
    .NUM_LINES(NUM_LINES), .NUM_SLOTS(NUM_SLOTS), .CORE_W(CORE_W)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_line(req_line),
    .rd_vld (rd_vld),
    .rd_ptr (rd_ptr),
    .wr_en  (state_q == ST_DONE),
    .wr_line(line_q),
    .wr_vld (nxt_vld_q),
    .wr_ptr (nxt_ptr_q)
  );

  sharer_dir_update #(
    .NUM_SLOTS(NUM_SLOTS), .CORE_W(CORE_W)
  ) u_update (
    .op_i      (dir_op_e'(req_op)),
    .core_i    (req_core),
    .vld_i     (rd_vld),
    .ptr_i     (rd_ptr),
    .inv_mask_o(upd_mask),
    .vld_o     (upd_vld),
    .ptr_o     (upd_ptr)
  );

  sharer_dir_pick #(.W(NUM_SLOTS)) u_pick (
    .mask (mask_q),
    .first(pick_first),
    .idx  (pick_idx)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign inv_valid = (state_q == ST_SEND);
  assign done      = (state_q == ST_DONE);
  assign inv_core  = cur_ptr_q[pick_idx*CORE_W +: CORE_W];
  assign inv_line  = line_q;

  assign accept  = req_valid && req_ready;
  assign fire    = inv_valid && inv_ready;
  assign load_en = accept;
  assign mask_en = accept || fire;

  always_comb begin
    mask_d = mask_q;
    if (accept)    mask_d = upd_mask;
    else if (fire) mask_d = mask_q & ~pick_first;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = (upd_mask != '0) ? ST_SEND : ST_DONE;
      ST_SEND: if (fire && ((mask_q & ~pick_first) == '0)) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q      <= DIR_NOP;
      line_q    <= '0;
      core_q    <= '0;
      cur_ptr_q <= '0;
      nxt_vld_q <= '0;
      nxt_ptr_q <= '0;
    end else if (load_en) begin
      op_q      <= dir_op_e'(req_op);
      line_q    <= req_line;
      core_q    <= req_core;
      cur_ptr_q <= rd_ptr;
      nxt_vld_q <= upd_vld;
      nxt_ptr_q <= upd_ptr;
    end
  end

  // R7: a stalled invalidate keeps its content
  assert_inv_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_core) && $stable(inv_line)));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R8: no new request is taken while messages or completion are pending
  assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inv_valid || done) |-> !req_ready);

  // R5: an exclusive writer is never sent its own invalidate
  assert_no_self_inv_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inv_valid && op_q == DIR_WR) |-> (inv_core != core_q));

  // R7: done follows the acceptance of the final message
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inv_valid && inv_ready && $countones(mask_q) == 1) |=> done);

endmodule

// File: tb/sharer_dir_tb.sv
module sharer_dir_tb;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_op;
  logic [3:0] req_line;
  logic [2:0] req_core;
  logic       inv_valid;
  logic       inv_ready;
  logic [2:0] inv_core;
  logic [3:0] inv_line;
  logic       done;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  sharer_dir u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_line(req_line), .req_core(req_core),
    .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_core(inv_core), .inv_line(inv_line), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    chk(1'b0, "watchdog", cyc, 20000);
    finish_run();
  end

  // fields: op, line, core, expected count, expected targets oldest first, tag
  localparam int NV = 22;
  localparam logic [23:0] VECS [NV] = '{
    {2'd0, 4'd5, 3'd1, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2 first sharer
    {2'd0, 4'd5, 3'd2, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2
    {2'd0, 4'd5, 3'd1, 2'd0, 3'd0, 3'd0, 3'd0, 4'd3},  // R3 already listed
    {2'd0, 4'd5, 3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2 fills slots
    {2'd0, 4'd5, 3'd4, 2'd1, 3'd1, 3'd0, 3'd0, 4'd4},  // R4 overflow drops core 1
    {2'd1, 4'd5, 3'd7, 2'd3, 3'd2, 3'd3, 3'd4, 4'd5},  // R5 probe, R4 order
    {2'd0, 4'd5, 3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2
    {2'd1, 4'd5, 3'd0, 2'd1, 3'd7, 3'd0, 3'd0, 4'd5},  // R5 requester skipped
    {2'd0, 4'd2, 3'd6, 2'd0, 3'd0, 3'd0, 3'd0, 4'd9},  // R9 other line
    {2'd0, 4'd5, 3'd5, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2
    {2'd2, 4'd5, 3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 4'd6},  // R6 unlisted evict
    {2'd2, 4'd5, 3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 4'd6},  // R6 evict oldest
    {2'd1, 4'd5, 3'd1, 2'd1, 3'd5, 3'd0, 3'd0, 4'd6},  // R6 result probe
    {2'd1, 4'd2, 3'd1, 2'd1, 3'd6, 3'd0, 3'd0, 4'd9},  // R9 line 2 intact
    {2'd3, 4'd5, 3'd2, 2'd0, 3'd0, 3'd0, 3'd0, 4'd10}, // R10 ignored op
    {2'd1, 4'd5, 3'd2, 2'd1, 3'd1, 3'd0, 3'd0, 4'd10}, // R10 nothing changed
    {2'd0, 4'd5, 3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2
    {2'd0, 4'd5, 3'd4, 2'd0, 3'd0, 3'd0, 3'd0, 4'd2},  // R2 full again
    {2'd2, 4'd5, 3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 4'd6},  // R6 evict middle
    {2'd0, 4'd5, 3'd5, 2'd0, 3'd0, 3'd0, 3'd0, 4'd6},  // R6 freed slot reused
    {2'd0, 4'd5, 3'd6, 2'd1, 3'd2, 3'd0, 3'd0, 4'd4},  // R4 oldest is core 2
    {2'd1, 4'd5, 3'd4, 2'd2, 3'd5, 3'd6, 3'd0, 4'd5}   // R5 slot0 requester
  };

  task automatic run_req(input logic [1:0] op, input logic [3:0] line,
                         input logic [2:0] core, output int n,
                         output logic [2:0] got [3], output int lat,
                         output bit line_ok, output bit busy_ok,
                         output bit pulse_ok);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_line  = line;
    req_core  = core;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; lat = 0; line_ok = 1; busy_ok = 1;
    got[0] = '0; got[1] = '0; got[2] = '0;
    while (!done && lat < 40) begin
      if (req_ready) busy_ok = 0;
      if (inv_valid && inv_ready) begin
        if (n < 3) got[n] = inv_core;
        if (inv_line != line) line_ok = 0;
        n++;
      end
      lat++;
      @(negedge clk);
    end
    if (req_ready) busy_ok = 0;
    @(negedge clk);
    pulse_ok = !done;
  endtask

  initial begin
    int n, lat;
    logic [2:0] got [3];
    bit line_ok, busy_ok, pulse_ok;

    req_valid = 1'b0; req_op = '0; req_line = '0; req_core = '0;
    inv_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(inv_valid == 1'b0, "R1 inv_valid", int'(inv_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    // R1: empty lines produce no invalidates on a write
    run_req(2'd1, 4'd0, 3'd3, n, got, lat, line_ok, busy_ok, pulse_ok);
    chk(n == 0, "R1 line 0 empty", n, 0);
    run_req(2'd1, 4'd15, 3'd0, n, got, lat, line_ok, busy_ok, pulse_ok);
    chk(n == 0, "R1 line 15 empty", n, 0);
    chk(lat == 0, "R1 done one cycle after accept", lat, 0);

    for (int v = 0; v < NV; v++) begin
      logic [23:0] e;
      string tag;
      int en;
      e = VECS[v];
      tag = $sformatf("R%0d vec%0d", int'(e[3:0]), v);
      en = int'(e[14:13]);
      run_req(e[23:22], e[21:18], e[17:15], n, got, lat, line_ok, busy_ok, pulse_ok);
      chk(n == en, {tag, " count"}, n, en);
      if (en > 0) chk(got[0] == e[12:10], {tag, " target0"}, int'(got[0]), int'(e[12:10]));
      if (en > 1) chk(got[1] == e[9:7],   {tag, " target1"}, int'(got[1]), int'(e[9:7]));
      if (en > 2) chk(got[2] == e[6:4],   {tag, " target2"}, int'(got[2]), int'(e[6:4]));
      chk(lat == en, {tag, " R7 done timing"}, lat, en);
      chk(pulse_ok, {tag, " R7 done width"}, 0, 1);
      chk(line_ok, {tag, " R7 inv_line"}, 0, 1);
      chk(busy_ok, {tag, " R8 ready low while busy"}, 0, 1);
    end

    // R7: stalled invalidate holds and done waits
    run_req(2'd0, 4'd9, 3'd1, n, got, lat, line_ok, busy_ok, pulse_ok);
    run_req(2'd0, 4'd9, 3'd2, n, got, lat, line_ok, busy_ok, pulse_ok);
    @(negedge clk);
    inv_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd1; req_line = 4'd9; req_core = 3'd3;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(inv_valid == 1'b1, "R7 stall valid held", int'(inv_valid), 1);
      chk(inv_core == 3'd1, "R7 stall core held", int'(inv_core), 1);
      chk(inv_line == 4'd9, "R7 stall line held", int'(inv_line), 9);
      chk(done == 1'b0, "R7 no early done", int'(done), 0);
      chk(req_ready == 1'b0, "R8 ready low in stall", int'(req_ready), 0);
      if (k < 2) @(negedge clk);
    end
    inv_ready = 1'b1;
    @(negedge clk);
    chk(inv_valid && inv_core == 3'd2, "R5 second target after stall", int'(inv_core), 2);
    @(negedge clk);
    chk(done == 1'b1, "R7 done after last accept", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R8 ready back after done", int'(req_ready), 1);

    finish_run();
  end

endmodule